// File: doc/BRIEF.md
# Thirty-Two Pin General-Purpose I/O Controller

This block is a word-addressed general-purpose I/O peripheral for thirty-two pins. Software reaches it through a simple register bus made of a write strobe, a read strobe, a word address and 32-bit write and read data. For each pin it keeps an output value, a drive-enable bit and an open-drain bit. It also keeps two 2-bit source fields: one picks where the pin's output value comes from, and the other picks where its drive enable comes from. Either the pin's register bits are used, or one of three alternate-function inputs supplied by neighbouring logic.

On the pad side the block produces an output level and an output enable for each pin. It takes in the raw pad levels and passes them through a two-flop synchronizer; the synchronized value is the readable input register. Every pin-indexed vector follows one bit order: pin n sits at bit 31-n, so pin 0 is the most significant bit. The select fields are 2 bits wide and are spread over a low word and a high word.

Top module: `pinbank_ctrl`

## Requirements
- R1: After reset every storage register reads zero, `pad_oe` and `pad_out` are zero, and `bus_rdata` is zero.
- R2: Word addresses 0 to 6 hold, in turn, the output value, drive enable, output-select low, output-select high, enable-select low, enable-select high and open-drain words. Words 8 to 10 and 12 to 17 are plain storage. A write to any of these words is read back unchanged.
- R3: A pin-indexed bit for pin n is bit 31-n of every register and of every pad vector, so writing 0x80000000 to the drive-enable word affects only pin 0, which is bit 31 of `pad_oe`.
- R4: When both source fields of a pin are 00 and its open-drain bit is 0, `pad_out` for that pin equals its output-value bit, and `pad_oe` equals its drive-enable bit (1 drives, 0 floats). Both change in the cycle after the write.
- R5: Pins 0-15 take their output-select field from the low word and pins 16-31 from the high word, at bits [31-2m:30-2m] where m = n mod 16. A value k of 1, 2 or 3 routes `alt_dout[k-1]` to the pin's output in place of the output-value bit.
- R6: The enable-select fields use the same layout in their own low and high words. A value k of 1, 2 or 3 routes `alt_oe[k-1]` to the pin's output enable in place of the drive-enable bit.
- R7: With a pin's open-drain bit at 1, `pad_out` is 0 and `pad_oe` is the inverse of the selected output value, whatever the selected drive enable says.
- R8: Word 7 returns the pad levels after two clock edges of synchronization. A read that samples in the same edge as a pad change, or in the edge after it, still returns the old level. Writes to word 7 are ignored.
- R9: Word 11 and words 18 to 31 read as zero and ignore writes.
- R10: Read data is registered: it is loaded at the edge where `bus_rd` is 1, and holds its value while `bus_rd` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Raw pad levels, pin n at bit 31-n |
| pad_out | output | 32 | Pad output level, pin n at bit 31-n |
| pad_oe | output | 32 | Pad output enable, pin n at bit 31-n |
| alt_dout | input | 3x32 | Alternate-function output values, index k-1 for select value k |
| alt_oe | input | 3x32 | Alternate-function output enables, index k-1 for select value k |

## Verification
A corrupted configuration bit shows on `pad_out` or `pad_oe` in the very next cycle, because the pad path is combinational from the registers. That makes a wrong bit position, a swapped low/high select word or a wrong open-drain polarity visible as soon as a write completes, before any read. A wrong synchronizer depth moves the cycle in which word 7 first shows a new pad level, so reads placed exactly at edges one, two and three after a pad change expose it. Faults in the read path, such as a wrong word decode or read data that is not held, show one cycle after the read strobe.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

    localparam int PINS       = 32;
    localparam int DATA_W     = PINS;
    localparam int HALF_PINS  = PINS / 2;
    localparam int SEL_W      = 2;
    localparam int ALT_N      = (1 << SEL_W) - 1;
    localparam int ADDR_W     = 5;
    localparam int SYNC_DEPTH = 2;

    localparam int W_DOUT     = 0;
    localparam int W_DRIVE    = 1;
    localparam int W_OSEL_LO  = 2;
    localparam int W_OSEL_HI  = 3;
    localparam int W_TSEL_LO  = 4;
    localparam int W_TSEL_HI  = 5;
    localparam int W_ODRAIN   = 6;
    localparam int W_LEVEL    = 7;
    localparam int RX_BASE    = 8;
    localparam int RX_WORDS   = 3;
    localparam int W_RSV      = 11;
    localparam int ISEL_BASE  = 12;
    localparam int ISEL_WORDS = 6;

    typedef struct packed {
        logic [DATA_W-1:0] dout;
        logic [DATA_W-1:0] drive;
        logic [DATA_W-1:0] osel_lo;
        logic [DATA_W-1:0] osel_hi;
        logic [DATA_W-1:0] tsel_lo;
        logic [DATA_W-1:0] tsel_hi;
        logic [DATA_W-1:0] odrain;
    } pin_cfg_t;

    typedef struct packed {
        pin_cfg_t                              cfg;
        logic [RX_WORDS-1:0][DATA_W-1:0]       rx;
        logic [ISEL_WORDS-1:0][DATA_W-1:0]     isel;
        logic [DATA_W-1:0]                     rdata;
    } reg_state_t;

    function automatic logic pick_src(input logic [SEL_W-1:0] sel,
                                      input logic             reg_v,
                                      input logic [ALT_N-1:0] alt_v);
        logic r;
        r = reg_v;
        for (int k = 1; k <= ALT_N; k++) begin
            if (sel == SEL_W'(k)) r = alt_v[k-1];
        end
        return r;
    endfunction

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int STAGES = 2,
    parameter int W      = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/pinbank_regfile.sv
module pinbank_regfile
    import pinbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] level,
    output pin_cfg_t          cfg,
    output logic [DATA_W-1:0] rdata
);

    reg_state_t st_d, st_q;
    logic [DATA_W-1:0] rd_word;

    always_comb begin
        rd_word = '0;
        case (addr)
            ADDR_W'(W_DOUT):    rd_word = st_q.cfg.dout;
            ADDR_W'(W_DRIVE):   rd_word = st_q.cfg.drive;
            ADDR_W'(W_OSEL_LO): rd_word = st_q.cfg.osel_lo;
            ADDR_W'(W_OSEL_HI): rd_word = st_q.cfg.osel_hi;
            ADDR_W'(W_TSEL_LO): rd_word = st_q.cfg.tsel_lo;
            ADDR_W'(W_TSEL_HI): rd_word = st_q.cfg.tsel_hi;
            ADDR_W'(W_ODRAIN):  rd_word = st_q.cfg.odrain;
            ADDR_W'(W_LEVEL):   rd_word = level;
            default: begin
                for (int k = 0; k < RX_WORDS; k++) begin
                    if (addr == ADDR_W'(RX_BASE + k)) rd_word = st_q.rx[k];
                end
                for (int k = 0; k < ISEL_WORDS; k++) begin
                    if (addr == ADDR_W'(ISEL_BASE + k)) rd_word = st_q.isel[k];
                end
            end
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (addr)
                ADDR_W'(W_DOUT):    st_d.cfg.dout    = wdata;
                ADDR_W'(W_DRIVE):   st_d.cfg.drive   = wdata;
                ADDR_W'(W_OSEL_LO): st_d.cfg.osel_lo = wdata;
                ADDR_W'(W_OSEL_HI): st_d.cfg.osel_hi = wdata;
                ADDR_W'(W_TSEL_LO): st_d.cfg.tsel_lo = wdata;
                ADDR_W'(W_TSEL_HI): st_d.cfg.tsel_hi = wdata;
                ADDR_W'(W_ODRAIN):  st_d.cfg.odrain  = wdata;
                default: begin
                    for (int k = 0; k < RX_WORDS; k++) begin
                        if (addr == ADDR_W'(RX_BASE + k)) st_d.rx[k] = wdata;
                    end
                    for (int k = 0; k < ISEL_WORDS; k++) begin
                        if (addr == ADDR_W'(ISEL_BASE + k)) st_d.isel[k] = wdata;
                    end
                end
            endcase
        end
        if (rd_en) st_d.rdata = rd_word;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cfg   = st_q.cfg;
    assign rdata = st_q.rdata;

endmodule

// File: rtl/pinbank_pinmux.sv
module pinbank_pinmux
    import pinbank_pkg::*;
(
    input  pin_cfg_t                      cfg,
    input  logic [ALT_N-1:0][DATA_W-1:0]  alt_dout,
    input  logic [ALT_N-1:0][DATA_W-1:0]  alt_oe,
    output logic [DATA_W-1:0]             pad_out,
    output logic [DATA_W-1:0]             pad_oe
);

    for (genvar b = 0; b < PINS; b++) begin : g_pin
        localparam int PIN = PINS - 1 - b;
        localparam int M   = PIN % HALF_PINS;
        localparam int FB  = DATA_W - 1 - SEL_W * M;

        logic [SEL_W-1:0] osel, tsel;
        logic [ALT_N-1:0] alt_v, alt_e;
        logic             src_out, src_oe, pin_out, pin_oe;

        if (PIN < HALF_PINS) begin : g_lo
            assign osel = cfg.osel_lo[FB -: SEL_W];
            assign tsel = cfg.tsel_lo[FB -: SEL_W];
        end else begin : g_hi
            assign osel = cfg.osel_hi[FB -: SEL_W];
            assign tsel = cfg.tsel_hi[FB -: SEL_W];
        end

        for (genvar k = 0; k < ALT_N; k++) begin : g_alt
            assign alt_v[k] = alt_dout[k][b];
            assign alt_e[k] = alt_oe[k][b];
        end

        always_comb begin
            src_out = pick_src(osel, cfg.dout[b], alt_v);
            src_oe  = pick_src(tsel, cfg.drive[b], alt_e);
            if (cfg.odrain[b]) begin
                pin_out = 1'b0;
                pin_oe  = ~src_out;
            end else begin
                pin_out = src_out;
                pin_oe  = src_oe;
            end
        end

        assign pad_out[b] = pin_out;
        assign pad_oe[b]  = pin_oe;
    end

endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
    import pinbank_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [DATA_W-1:0]             bus_wdata,
    output logic [DATA_W-1:0]             bus_rdata,
    input  logic [DATA_W-1:0]             pad_in,
    output logic [DATA_W-1:0]             pad_out,
    output logic [DATA_W-1:0]             pad_oe,
    input  logic [ALT_N-1:0][DATA_W-1:0]  alt_dout,
    input  logic [ALT_N-1:0][DATA_W-1:0]  alt_oe
);

    pin_cfg_t          cfg;
    logic [DATA_W-1:0] level;
    logic [DATA_W-1:0] od_mask;

    pinbank_sync #(
        .STAGES (SYNC_DEPTH),
        .W      (DATA_W)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pad_in),
        .sync_out (level)
    );

    pinbank_regfile u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_wr),
        .rd_en (bus_rd),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .level (level),
        .cfg   (cfg),
        .rdata (bus_rdata)
    );

    pinbank_pinmux u_mux (
        .cfg      (cfg),
        .alt_dout (alt_dout),
        .alt_oe   (alt_oe),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );

    assign od_mask = cfg.odrain;

endmodule

// File: rtl/pinbank_ctrl_chk.sv
module pinbank_ctrl_chk
    import pinbank_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] pad_in,
    input logic [DATA_W-1:0] pad_out,
    input logic [DATA_W-1:0] pad_oe,
    input logic [DATA_W-1:0] od_mask,
    input logic [DATA_W-1:0] level
);

    logic [1:0] settle_q;

    always_ff @(posedge clk) begin
        if (rst)                  settle_q <= '0;
        else if (settle_q != 2'd3) settle_q <= settle_q + 2'd1;
    end

    AST_RESET_FLOAT: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pad_oe == '0 && pad_out == '0 && bus_rdata == '0)); // R1

    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (rst)
        (od_mask & pad_out) == '0); // R7

    AST_SYNC_DEPTH: assert property (@(posedge clk) disable iff (rst)
        (settle_q >= 2'd2) |-> (level == $past(pad_in, 2))); // R8

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == ADDR_W'(W_RSV)) |=> (bus_rdata == '0)); // R9

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata)); // R10

endmodule

bind pinbank_ctrl pinbank_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .od_mask   (od_mask),
    .level     (level)
);

// File: tb/pinbank_ctrl_tb.sv
module pinbank_ctrl_tb;
    import pinbank_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic                         clk = 1'b0;
    logic                         rst;
    logic                         bus_wr, bus_rd;
    logic [ADDR_W-1:0]            bus_addr;
    logic [DATA_W-1:0]            bus_wdata, bus_rdata;
    logic [DATA_W-1:0]            pad_in, pad_out, pad_oe;
    logic [ALT_N-1:0][DATA_W-1:0] alt_dout, alt_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pinbank_ctrl u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .alt_dout  (alt_dout),
        .alt_oe    (alt_oe)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // All bus tasks start and end at a falling edge.
    task automatic bus_write(input int a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input int a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = ADDR_W'(a);
        @(posedge clk); @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic clear_cfg();
        for (int a = 0; a < 7; a++) bus_write(a, 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1", "pad_oe after reset", pad_oe, 32'h0);
        chk("R1", "pad_out after reset", pad_out, 32'h0);
        chk("R1", "rdata after reset", bus_rdata, 32'h0);
        for (int a = 0; a < 18; a++) begin
            bus_read(a, d);
            chk("R1", $sformatf("word %0d after reset", a), d, 32'h0);
        end
    endtask

    task automatic t_regs_rw();
        logic [31:0] d;
        for (int a = 0; a < 18; a++) begin
            if (a != W_LEVEL && a != W_RSV) bus_write(a, 32'h1357_0000 + 32'(a * 32'h111));
        end
        for (int a = 0; a < 18; a++) begin
            if (a != W_LEVEL && a != W_RSV) begin
                bus_read(a, d);
                chk("R2", $sformatf("readback word %0d", a), d, 32'h1357_0000 + 32'(a * 32'h111));
            end
        end
        clear_cfg();
    endtask

    task automatic t_drive();
        alt_dout = '1; alt_oe = '1;
        bus_write(W_DOUT, 32'hA5A5_0F0F);
        bus_write(W_DRIVE, 32'hFFFF_0000);
        chk("R4", "pad_out follows value reg", pad_out, 32'hA5A5_0F0F);
        chk("R4", "pad_oe follows drive reg", pad_oe, 32'hFFFF_0000);
        bus_write(W_DRIVE, 32'h8000_0000);
        chk("R3", "pin 0 drive at bit 31", pad_oe, 32'h8000_0000);
        bus_write(W_DOUT, 32'h0000_0001);
        chk("R3", "pin 31 value at bit 0", pad_out, 32'h0000_0001);
        clear_cfg();
    endtask

    task automatic t_sel_out();
        alt_dout[0] = 32'h8000_0000;
        alt_dout[1] = 32'h0000_8000;
        alt_dout[2] = 32'h0000_0001;
        bus_write(W_DOUT, 32'h0);
        bus_write(W_OSEL_LO, 32'h4000_0001);
        bus_write(W_OSEL_HI, 32'h8000_0003);
        chk("R5", "alternates routed to pins 0,16,31", pad_out, 32'h8000_8001);
        alt_dout[0] = 32'h0;
        #1;
        chk("R5", "pin 0 follows alt 1 live", pad_out, 32'h0000_8001);
        bus_write(W_OSEL_HI, 32'h0);
        chk("R5", "high word cleared returns pins 16,31 to regs", pad_out, 32'h0);
        clear_cfg();
    endtask

    task automatic t_sel_oe();
        alt_oe[0] = 32'h0; alt_oe[1] = 32'h0;
        alt_oe[2] = 32'h1234_5678;
        bus_write(W_TSEL_LO, 32'hFFFF_FFFF);
        chk("R6", "low pins take enable from alt 3", pad_oe, 32'h1234_0000);
        bus_write(W_TSEL_LO, 32'h0);
        bus_write(W_TSEL_HI, 32'h5555_5555);
        alt_oe[0] = 32'hF0F0_F0F0;
        #1;
        chk("R6", "high pins take enable from alt 1", pad_oe, 32'h0000_F0F0);
        clear_cfg();
    endtask

    task automatic t_opendrain();
        bus_write(W_DOUT, 32'h0000_FFFF);
        bus_write(W_ODRAIN, 32'hFF00_FF00);
        chk("R7", "open-drain pad_oe", pad_oe, 32'hFF00_0000);
        chk("R7", "open-drain pad_out", pad_out, 32'h0000_00FF);
        bus_write(W_DRIVE, 32'hFFFF_FFFF);
        chk("R7", "open-drain ignores drive bit", pad_oe, 32'hFFFF_00FF);
        clear_cfg();
    endtask

    task automatic t_sync();
        logic [31:0] d;
        pad_in = 32'hDEAD_BEEF;
        bus_read(W_LEVEL, d);
        chk("R8", "level one edge after change", d, 32'h0);
        bus_read(W_LEVEL, d);
        chk("R8", "level two edges after change", d, 32'h0);
        bus_read(W_LEVEL, d);
        chk("R8", "level three edges after change", d, 32'hDEAD_BEEF);
        bus_write(W_LEVEL, 32'h0);
        bus_read(W_LEVEL, d);
        chk("R8", "write to level word ignored", d, 32'hDEAD_BEEF);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        bus_write(W_RSV, 32'hFFFF_FFFF);
        bus_read(W_RSV, d);
        chk("R9", "reserved word reads zero", d, 32'h0);
        bus_write(20, 32'hFFFF_FFFF);
        bus_read(20, d);
        chk("R9", "unmapped word reads zero", d, 32'h0);
        chk("R9", "pads untouched by ignored writes", pad_oe, 32'h0);
    endtask

    task automatic t_hold();
        logic [31:0] d;
        bus_write(W_DRIVE, 32'h0BAD_F00D);
        bus_read(W_DRIVE, d);
        chk("R10", "read returns drive word", d, 32'h0BAD_F00D);
        bus_addr = ADDR_W'(W_DOUT);
        bus_write(W_DRIVE, 32'h0);
        @(posedge clk); @(negedge clk);
        chk("R10", "rdata held without read strobe", bus_rdata, 32'h0BAD_F00D);
        clear_cfg();
    endtask

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        pad_in = '0; alt_dout = '0; alt_oe = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs_rw();
        t_drive();
        t_sel_out();
        t_sel_oe();
        t_opendrain();
        t_sync();
        t_reserved();
        t_hold();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule